// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector with Debounce

This block watches one port of general-purpose pins and turns pin activity into interrupt requests. Every pin has its own settings: a trigger-style bit that picks edge or level detection, a pair of direction enables (falling/low and rising/high), and a debounce enable. The same pair of direction enables means a transition in edge style and a held level in level style. The pin inputs must already be synchronized to the block clock.

A shared debounce control word selects the debounce sample period and the clock that drives the sample counter. That clock is either the system clock or a slow tick supplied as a one-cycle enable. The same word also holds a bit that lets the block stop tracking pins whose interrupts are both disabled. Debounce applies only to pins in edge style, and a new level must be seen on two debounce samples in a row before it counts as an edge.

Each detected event sets a sticky per-pin source flag. Software clears a flag by writing 1 to its bit. A single request output is high while any flag is set.

Top module: `gpio_irq_detect`

## Requirements
- R1: During and right after a synchronous reset, every source flag and the request output are 0.
- R2: In edge style (style bit 0) with debounce off, a 0-to-1 pin change with the rising enable set, or a 1-to-0 change with the falling enable set, sets that pin's flag at the first clock edge after the change.
- R3: A pin change in a direction whose enable is 0 does not set the flag.
- R4: In level style (style bit 1), the flag sets on every clock while the pin is low with the falling enable set, or high with the rising enable set. A flag cleared while its level is still active reads 0 for one cycle and is set again at the following edge.
- R5: While the clear strobe is high, each clear-data bit of 1 clears its flag at that clock edge, and each 0 bit leaves its flag unchanged. A clear takes priority over a set for the same pin at the same edge.
- R6: The request output is 1 exactly when at least one source flag is 1.
- R7: With debounce enabled in edge style, an edge counts only when the new level is seen on two consecutive debounce samples. A pulse that does not reach two samples raises no flag.
- R8: Debounce samples happen once every 2^SEL source clocks, where SEL is control bits [3:0]. SEL=0 samples on every source clock.
- R9: Control bit 4 picks the sample clock source. 0 selects the system clock and 1 selects the slow tick input. With source 1 and no tick, no debounced edge is accepted.
- R10: The debounce enable has no effect in level style.
- R11: When control bit 5 is 0, a pin with both direction enables at 0 freezes its stored level. Enabling it after the pin has changed then reports that change as an edge. When bit 5 is 1, the stored level follows the pin at all times, so enabling a direction later reports nothing.
- R12: Without a clear, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_PINS | Synchronized pin levels |
| trig_level | input | N_PINS | Per-pin style: 0 edge, 1 level |
| dbnc_en | input | N_PINS | Per-pin debounce enable (edge style only) |
| fall_low_en | input | N_PINS | Per-pin falling-edge / low-level enable |
| rise_high_en | input | N_PINS | Per-pin rising-edge / high-level enable |
| dbnc_ctrl | input | 6 | [3:0] sample period select, [4] slow source, [5] keep tracking disabled pins |
| slow_tick | input | 1 | One-cycle enable from the slow clock domain |
| clr_wr | input | 1 | Flag clear strobe |
| clr_data | input | N_PINS | Write-1-to-clear mask |
| src_flag | output | N_PINS | Sticky interrupt source flags |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted stored level in a pin detector shows up at the ports as a spurious flag, or as a missing one. In edge style without debounce the effect appears on the first clock after the pin or its enables next change; with debounce it appears at the second sample after that. A wrong sample counter moves the boundary between an accepted pulse and a rejected one, so directed pulses just shorter and just longer than two periods expose it within a few periods. A flag register that drops a set, ignores a clear, or loses its clear-over-set priority shows on `src_flag` and `irq` at the very next edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int unsigned PINS_DEFAULT = 8;
    localparam int unsigned SEL_W        = 4;
    localparam int unsigned STROBE_CNT_W = 1 << SEL_W;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_style_e;

    // bit 5: keep tracking disabled pins, bit 4: slow source, [3:0]: period select
    typedef struct packed {
        logic             keep_track;
        logic             slow_src;
        logic [SEL_W-1:0] period_sel;
    } dbnc_cfg_t;

    function automatic logic dir_hit(input logic lvl, input logic fall_en, input logic rise_en);
        return (lvl & rise_en) | (~lvl & fall_en);
    endfunction

endpackage

// File: rtl/gpio_dbnc_strobe.sv
`timescale 1ns/1ps
module gpio_dbnc_strobe
    import gpio_irq_pkg::*;
#(
    parameter int unsigned CNT_W = STROBE_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_src,
    input  logic             slow_tick,
    input  logic [SEL_W-1:0] period_sel,
    output logic             strobe
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic             src_en;

    assign src_en = slow_src ? slow_tick : 1'b1;
    assign mask   = (CNT_W'(1) << period_sel) - CNT_W'(1);
    assign strobe = src_en && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (src_en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/gpio_pin_detect.sv
`timescale 1ns/1ps
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pin,
    input  trig_style_e style,
    input  logic        dbnc_en,
    input  logic        fall_en,
    input  logic        rise_en,
    input  logic        strobe,
    input  logic        keep_track,
    output logic        hit
);

    logic stable_lvl;
    logic last_sample;
    logic run;
    logic use_dbnc;
    logic confirmed;

    assign run       = keep_track | fall_en | rise_en;
    assign use_dbnc  = (style == TRIG_EDGE) && dbnc_en;
    assign confirmed = strobe && (pin == last_sample);

    always_ff @(posedge clk) begin
        if (rst) begin
            stable_lvl  <= 1'b0;
            last_sample <= 1'b0;
        end else if (run) begin
            if (strobe) begin
                last_sample <= pin;
            end
            if (!use_dbnc) begin
                stable_lvl <= pin;
            end else if (confirmed) begin
                stable_lvl <= pin;
            end
        end
    end

    always_comb begin
        hit = 1'b0;
        if (run) begin
            if (style == TRIG_LEVEL) begin
                hit = dir_hit(pin, fall_en, rise_en);
            end else if (use_dbnc) begin
                hit = confirmed && (pin != stable_lvl) && dir_hit(pin, fall_en, rise_en);
            end else begin
                hit = (pin != stable_lvl) && dir_hit(pin, fall_en, rise_en);
            end
        end
    end

endmodule

// File: rtl/gpio_irq_flags.sv
`timescale 1ns/1ps
module gpio_irq_flags #(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] set_req,
    input  logic              clr_wr,
    input  logic [N_PINS-1:0] clr_data,
    output logic [N_PINS-1:0] flags,
    output logic              any
);

    logic [N_PINS-1:0] clr_mask;

    assign clr_mask = clr_wr ? clr_data : '0;
    assign any      = |flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags | set_req) & ~clr_mask;
        end
    end

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS = PINS_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] trig_level,
    input  logic [N_PINS-1:0] dbnc_en,
    input  logic [N_PINS-1:0] fall_low_en,
    input  logic [N_PINS-1:0] rise_high_en,
    input  logic [5:0]        dbnc_ctrl,
    input  logic              slow_tick,
    input  logic              clr_wr,
    input  logic [N_PINS-1:0] clr_data,
    output logic [N_PINS-1:0] src_flag,
    output logic              irq
);

    dbnc_cfg_t         cfg;
    logic              strobe;
    logic [N_PINS-1:0] pin_hit;

    assign cfg = dbnc_cfg_t'(dbnc_ctrl);

    gpio_dbnc_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .slow_src   (cfg.slow_src),
        .slow_tick  (slow_tick),
        .period_sel (cfg.period_sel),
        .strobe     (strobe)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_pin_detect u_det (
            .clk        (clk),
            .rst        (rst),
            .pin        (pin_in[g]),
            .style      (trig_style_e'(trig_level[g])),
            .dbnc_en    (dbnc_en[g]),
            .fall_en    (fall_low_en[g]),
            .rise_en    (rise_high_en[g]),
            .strobe     (strobe),
            .keep_track (cfg.keep_track),
            .hit        (pin_hit[g])
        );
    end

    gpio_irq_flags #(.N_PINS(N_PINS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_req  (pin_hit),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .flags    (src_flag),
        .any      (irq)
    );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk #(
    parameter int unsigned N_PINS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_PINS-1:0] pin_in,
    input logic [N_PINS-1:0] trig_level,
    input logic [N_PINS-1:0] fall_low_en,
    input logic [N_PINS-1:0] rise_high_en,
    input logic              clr_wr,
    input logic [N_PINS-1:0] clr_data,
    input logic [N_PINS-1:0] src_flag,
    input logic              irq
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (src_flag == '0)); // R1

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((src_flag & $past(clr_data)) == '0)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((src_flag & $past(src_flag)) == $past(src_flag))); // R12

    AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((src_flag & $past(trig_level & rise_high_en & pin_in))
                     == $past(trig_level & rise_high_en & pin_in))); // R4

    AST_LEVEL_LOW_SETS: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((src_flag & $past(trig_level & fall_low_en & ~pin_in))
                     == $past(trig_level & fall_low_en & ~pin_in))); // R4

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((src_flag & $past(~(fall_low_en | rise_high_en) & ~src_flag)) == '0)); // R3

    AST_IRQ_RISES_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(src_flag) == '0); // R6

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N_PINS(N_PINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pin_in       (pin_in),
    .trig_level   (trig_level),
    .fall_low_en  (fall_low_en),
    .rise_high_en (rise_high_en),
    .clr_wr       (clr_wr),
    .clr_data     (clr_data),
    .src_flag     (src_flag),
    .irq          (irq)
);

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] trig_level = '0;
    logic [N-1:0] dbnc_en = '0;
    logic [N-1:0] fall_low_en = '0;
    logic [N-1:0] rise_high_en = '0;
    logic [5:0]   dbnc_ctrl = '0;
    logic         slow_tick = 1'b0;
    logic         clr_wr = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic [N-1:0] src_flag;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    gpio_irq_detect #(.N_PINS(N)) i_gpio_irq_detect (
        .clk          (clk),
        .rst          (rst),
        .pin_in       (pin_in),
        .trig_level   (trig_level),
        .dbnc_en      (dbnc_en),
        .fall_low_en  (fall_low_en),
        .rise_high_en (rise_high_en),
        .dbnc_ctrl    (dbnc_ctrl),
        .slow_tick    (slow_tick),
        .clr_wr       (clr_wr),
        .clr_data     (clr_data),
        .src_flag     (src_flag),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [N-1:0] m);
        clr_wr   = 1'b1;
        clr_data = m;
        wait_clk(1);
        clr_wr   = 1'b0;
        clr_data = '0;
    endtask

    task automatic quiesce();
        fall_low_en  = '0;
        rise_high_en = '0;
        trig_level   = '0;
        dbnc_en      = '0;
        wait_clk(1);
        clear_flags('1);
        wait_clk(1);
    endtask

    task automatic t_reset();
        chk("R1 flags after reset", 32'(src_flag), 0);
        chk("R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_edge_plain();
        rise_high_en[0] = 1'b1;
        fall_low_en[2]  = 1'b1;
        rise_high_en[1] = 1'b1;
        pin_in[2] = 1'b1;           // rising on pin2: only falling enabled
        wait_clk(2);
        chk("R3 rising with only fall enable", 32'(src_flag[2]), 0);
        pin_in[0] = 1'b1;
        wait_clk(1);
        chk("R2 rising edge flag", 32'(src_flag[0]), 1);
        chk("R6 irq with flag", 32'(irq), 1);
        pin_in[2] = 1'b0;
        wait_clk(1);
        chk("R2 falling edge flag", 32'(src_flag[2]), 1);
        pin_in[1] = 1'b1;
        wait_clk(1);
        pin_in[1] = 1'b0;           // falling on pin1: not enabled
        wait_clk(1);
        clear_flags(8'h02);
        wait_clk(2);
        chk("R3 falling with only rise enable", 32'(src_flag[1]), 0);
        wait_clk(3);
        chk("R12 flags held without clear", 32'(src_flag), 32'h05);
        clear_flags(8'h00);
        chk("R5 zero write keeps flags", 32'(src_flag), 32'h05);
        clear_flags(8'h01);
        chk("R5 write one clears only pin0", 32'(src_flag), 32'h04);
        clear_flags(8'h04);
        chk("R6 irq low with no flags", 32'(irq), 0);
        pin_in[0] = 1'b0;
        quiesce();
    endtask

    task automatic t_level();
        dbnc_ctrl       = 6'h0F;     // long debounce period, must not matter
        trig_level[3]   = 1'b1;
        dbnc_en[3]      = 1'b1;
        fall_low_en[3]  = 1'b1;      // pin3 is low
        wait_clk(1);
        chk("R4 R10 low level sets in one clock", 32'(src_flag[3]), 1);
        clr_wr = 1'b1; clr_data = 8'h08;
        wait_clk(1);
        clr_wr = 1'b0; clr_data = '0;
        chk("R5 clear wins while level active", 32'(src_flag[3]), 0);
        wait_clk(1);
        chk("R4 level flag sets again", 32'(src_flag[3]), 1);
        pin_in[3] = 1'b1;
        wait_clk(1);
        clear_flags(8'h08);
        wait_clk(2);
        chk("R4 inactive level stays clear", 32'(src_flag[3]), 0);
        rise_high_en[3] = 1'b1;
        wait_clk(1);
        chk("R4 high level with rise enable", 32'(src_flag[3]), 1);
        pin_in[3] = 1'b0;
        dbnc_ctrl = '0;
        quiesce();
    endtask

    task automatic t_debounce_sys();
        dbnc_ctrl       = 6'h02;     // system clock, period 4
        dbnc_en[7]      = 1'b1;
        rise_high_en[7] = 1'b1;
        wait_clk(10);
        pin_in[7] = 1'b1;
        wait_clk(2);
        pin_in[7] = 1'b0;
        wait_clk(12);
        chk("R7 R8 short pulse rejected at period 4", 32'(src_flag[7]), 0);
        pin_in[7] = 1'b1;
        wait_clk(12);
        chk("R7 held level accepted", 32'(src_flag[7]), 1);
        pin_in[7] = 1'b0;
        wait_clk(12);
        clear_flags(8'h80);
        dbnc_ctrl = 6'h00;           // period 1
        wait_clk(4);
        pin_in[7] = 1'b1;
        wait_clk(2);
        pin_in[7] = 1'b0;
        wait_clk(3);
        chk("R8 two-cycle pulse accepted at period 1", 32'(src_flag[7]), 1);
        quiesce();
    endtask

    task automatic t_debounce_slow();
        dbnc_ctrl       = 6'h30;     // keep tracking, slow source, period 1
        dbnc_en[6]      = 1'b1;
        rise_high_en[6] = 1'b1;
        wait_clk(2);
        pin_in[6] = 1'b1;
        wait_clk(20);
        chk("R9 no tick no debounced edge", 32'(src_flag[6]), 0);
        slow_tick = 1'b1; wait_clk(1); slow_tick = 1'b0;
        wait_clk(3);
        chk("R7 one sample not enough", 32'(src_flag[6]), 0);
        slow_tick = 1'b1; wait_clk(1); slow_tick = 1'b0;
        wait_clk(1);
        chk("R9 second tick confirms edge", 32'(src_flag[6]), 1);
        pin_in[6] = 1'b0;
        slow_tick = 1'b1; wait_clk(2); slow_tick = 1'b0;
        dbnc_ctrl = '0;
        quiesce();
    endtask

    task automatic t_gating();
        dbnc_ctrl = 6'h00;           // disabled pins freeze
        pin_in[4] = 1'b1;
        wait_clk(2);
        chk("R3 disabled pin sets nothing", 32'(src_flag[4]), 0);
        rise_high_en[4] = 1'b1;
        wait_clk(1);
        chk("R11 frozen level reports edge on enable", 32'(src_flag[4]), 1);
        quiesce();
        dbnc_ctrl = 6'h20;           // tracking always
        pin_in[5] = 1'b1;
        wait_clk(2);
        rise_high_en[5] = 1'b1;
        wait_clk(2);
        chk("R11 tracked level reports nothing on enable", 32'(src_flag[5]), 0);
        pin_in[4] = 1'b0;
        pin_in[5] = 1'b0;
        quiesce();
    endtask

    initial begin
        wait_clk(3);
        t_reset();
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_edge_plain();
        t_level();
        t_debounce_sys();
        t_debounce_slow();
        t_gating();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule